// File: doc/BRIEF.md
# Quadrature Sine/Cosine Lookup Stage

This block turns a phase word into a pair of signed cosine and sine words by table lookup, ready to feed a complex multiplier as a (cos, sin) vector. Only the upper bits of the phase address the table. The table stores a single quarter of a sine wave, and the quadrant bits choose the mirroring and the sign, so the storage is a quarter of a full-wave table. The cosine is read from the same quarter table at an angle a quarter turn ahead of the sine.

Two registered controls change the behaviour. A half-turn control forces the top table address bit to zero, so the angle wraps every 180 degrees instead of every 360. An active-low raw-select control bypasses the table and sends the phase word to the sine output and a second 16-bit word (the low bits of a phase accumulator) to the cosine output. Every input, including both controls, is registered on the same edge. The table path and the raw path have the same three-cycle latency, so a control change lines up exactly with the phase word sampled with it.

Top module: `quad_sincos_lut`

## Requirements
- R1: A synchronous active-high reset drives `cos_o` and `sin_o` to zero on the next clock edge, and they stay zero while reset is held.
- R2: Outputs appear exactly three rising edges after the inputs are sampled. A new input can be accepted on every cycle, and each result keeps its own controls.
- R3: In table mode, let a = phase[15:6] (10 bits), q = a[9:8] and i = a[7:0]. Let T[j] = floor(32767*sin((pi/2)*(j+0.5)/256) + 0.5) for j in 0..255. Then `sin_o` = T[q[0] ? 255-i : i], negated when q[1] is 1. So sine is never zero and never -32768.
- R4: In table mode, `cos_o` equals the R3 sine value for the angle index (a + 256) mod 1024.
- R5: When `half_turn_i` is 1, bit 9 of the angle index is treated as 0 before the R3 and R4 lookups. The result is that the table sine is never negative.
- R6: `half_turn_i` and `raw_sel_n_i` are registered with the phase. A control value applies only to the phase sampled in the same cycle.
- R7: When `raw_sel_n_i` is 0, `sin_o` equals `phase_sum_i` and `cos_o` equals `acc_lo_i`, with the R2 latency. `half_turn_i` has no effect on this path.
- R8: In table mode, phase bits 5..0 and `acc_lo_i` have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| phase_sum_i | input | 16 | Phase argument; its top 10 bits address the table; passed to sine in raw mode |
| acc_lo_i | input | 16 | Low accumulator bits, passed to cosine in raw mode |
| raw_sel_n_i | input | 1 | 0 selects the raw path, 1 selects the table |
| half_turn_i | input | 1 | 1 wraps the table angle modulo 180 degrees |
| cos_o | output | 16 | Registered signed cosine word |
| sin_o | output | 16 | Registered signed sine word |

## Verification
The bench targets the quadrant edges (indices 255/256, 511/512, 767/768, 1023 and 0). A design that mirrors or negates at the wrong quadrant gives the wrong magnitude or sign exactly there. It applies the half-turn mode to angles with the top bit set: a design that drops the mask returns negative sines. It also streams one input per cycle while the controls toggle, which catches a control register that is one stage off from the data (R6), and it checks that raw mode passes words through untouched even when the half-turn mode is set. Low phase bits and the accumulator word are changed in table mode and must leave the outputs unchanged.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
  typedef enum logic [0:0] {
    SRC_TABLE = 1'b0,
    SRC_RAW   = 1'b1
  } sc_src_e;
endpackage

// File: rtl/sc_in_reg.sv
`timescale 1ns/1ps
module sc_in_reg
  import sc_pkg::*;
#(
  parameter int PH_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] phase_i,
  input  logic [PH_W-1:0] acc_i,
  input  logic            raw_sel_n_i,
  input  logic            half_i,
  output logic [PH_W-1:0] phase_q,
  output logic [PH_W-1:0] acc_q,
  output sc_src_e         src_q,
  output logic            half_q
);
  // Stage 1: phase, accumulator bits and both mode controls share one edge (R6)
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      acc_q   <= '0;
      src_q   <= SRC_RAW;
      half_q  <= 1'b0;
    end else begin
      phase_q <= phase_i;
      acc_q   <= acc_i;
      src_q   <= raw_sel_n_i ? SRC_TABLE : SRC_RAW;
      half_q  <= half_i;
    end
  end
endmodule

// File: rtl/sc_addr_gen.sv
`timescale 1ns/1ps
module sc_addr_gen #(
  parameter int AW = 10
) (
  input  logic                 [AW-1:0] ang_i,
  input  logic                          half_i,
  output logic [1:0]           [AW-3:0] idx_o,
  output logic [1:0]                    neg_o
);
  localparam int QW = AW - 2;
  localparam int QD = 1 << QW;

  logic [AW-1:0] base;
  // Modulo-pi mode clears the top angle bit (R5)
  assign base = {ang_i[AW-1] & ~half_i, ang_i[AW-2:0]};

  // Lane 0 is sine, lane 1 is cosine: a quarter turn ahead (R4)
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [AW-1:0] ang;
    logic [1:0]    quad;
    logic [QW-1:0] low;
    assign ang  = base + AW'(g * QD);
    assign quad = ang[AW-1:AW-2];
    assign low  = ang[QW-1:0];
    assign idx_o[g] = quad[0] ? ~low : low;
    assign neg_o[g] = quad[1];
  end
endmodule

// File: rtl/sc_quarter_rom.sv
`timescale 1ns/1ps
module sc_quarter_rom #(
  parameter int OUT_W = 16,
  parameter int QW    = 8
) (
  input  logic             clk,
  input  logic [QW-1:0]    addr_a,
  input  logic [QW-1:0]    addr_b,
  output logic [OUT_W-1:0] data_a,
  output logic [OUT_W-1:0] data_b
);
  localparam int  QD      = 1 << QW;
  localparam real FS      = real'((1 << (OUT_W - 1)) - 1);
  localparam real HALF_PI = 1.5707963267948966;

  logic [OUT_W-1:0] rom [QD];

  // Half-sample offset keeps every entry nonzero and below full scale (R3)
  initial begin
    for (int k = 0; k < QD; k++) begin
      rom[k] = OUT_W'($rtoi(FS * $sin(HALF_PI * (real'(k) + 0.5) / real'(QD)) + 0.5));
    end
  end

  // Registered dual read so a block RAM can be inferred
  always_ff @(posedge clk) begin
    data_a <= rom[addr_a];
    data_b <= rom[addr_b];
  end
endmodule

// File: rtl/sc_out_stage.sv
`timescale 1ns/1ps
module sc_out_stage
  import sc_pkg::*;
#(
  parameter int PH_W  = 16,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  sc_src_e          src_i,
  input  logic [1:0]       neg_i,
  input  logic [PH_W-1:0]  raw_sin_i,
  input  logic [PH_W-1:0]  raw_cos_i,
  input  logic [OUT_W-1:0] mag_sin_i,
  input  logic [OUT_W-1:0] mag_cos_i,
  output logic [OUT_W-1:0] sin_o,
  output logic [OUT_W-1:0] cos_o
);
  // Stage 2 side registers aligned with the table read
  sc_src_e          src_q;
  logic [1:0]       neg_q;
  logic [OUT_W-1:0] raw_sin_q, raw_cos_q;
  sc_src_e          out_src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= SRC_RAW;
      neg_q     <= '0;
      raw_sin_q <= '0;
      raw_cos_q <= '0;
    end else begin
      src_q     <= src_i;
      neg_q     <= neg_i;
      raw_sin_q <= OUT_W'(raw_sin_i);
      raw_cos_q <= OUT_W'(raw_cos_i);
    end
  end

  logic [OUT_W-1:0] tab_sin, tab_cos;
  assign tab_sin = neg_q[0] ? -mag_sin_i : mag_sin_i;
  assign tab_cos = neg_q[1] ? -mag_cos_i : mag_cos_i;

  // Stage 3: same depth for table and raw paths (R2, R7)
  always_ff @(posedge clk) begin
    if (rst) begin
      sin_o     <= '0;
      cos_o     <= '0;
      out_src_q <= SRC_RAW;
    end else begin
      sin_o     <= (src_q == SRC_RAW) ? raw_sin_q : tab_sin;
      cos_o     <= (src_q == SRC_RAW) ? raw_cos_q : tab_cos;
      out_src_q <= src_q;
    end
  end

  // R3: table words are never zero and never the most negative code
  a_r3_table_range: assert property (@(posedge clk) disable iff (rst)
    (out_src_q == SRC_TABLE) |->
      (sin_o != '0) && (cos_o != '0) &&
      (sin_o != {1'b1, {(OUT_W-1){1'b0}}}) && (cos_o != {1'b1, {(OUT_W-1){1'b0}}}));
endmodule

// File: rtl/quad_sincos_lut.sv
`timescale 1ns/1ps
module quad_sincos_lut
  import sc_pkg::*;
#(
  parameter int PH_W  = 16,
  parameter int OUT_W = 16,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  phase_sum_i,
  input  logic [PH_W-1:0]  acc_lo_i,
  input  logic             raw_sel_n_i,
  input  logic             half_turn_i,
  output logic [OUT_W-1:0] cos_o,
  output logic [OUT_W-1:0] sin_o
);
  localparam int QW = AW - 2;

  logic [PH_W-1:0] ph_q, acc_q;
  sc_src_e         src_q;
  logic            half_q;

  sc_in_reg #(.PH_W(PH_W)) u_in (
    .clk(clk), .rst(rst),
    .phase_i(phase_sum_i), .acc_i(acc_lo_i),
    .raw_sel_n_i(raw_sel_n_i), .half_i(half_turn_i),
    .phase_q(ph_q), .acc_q(acc_q), .src_q(src_q), .half_q(half_q)
  );

  logic [1:0][QW-1:0] idx;
  logic [1:0]         neg;

  // Only the top AW phase bits address the table (R8)
  sc_addr_gen #(.AW(AW)) u_addr (
    .ang_i(ph_q[PH_W-1 -: AW]), .half_i(half_q),
    .idx_o(idx), .neg_o(neg)
  );

  logic [OUT_W-1:0] mag_sin, mag_cos;

  sc_quarter_rom #(.OUT_W(OUT_W), .QW(QW)) u_rom (
    .clk(clk), .addr_a(idx[0]), .addr_b(idx[1]),
    .data_a(mag_sin), .data_b(mag_cos)
  );

  sc_out_stage #(.PH_W(PH_W), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst(rst), .src_i(src_q), .neg_i(neg),
    .raw_sin_i(ph_q), .raw_cos_i(acc_q),
    .mag_sin_i(mag_sin), .mag_cos_i(mag_cos),
    .sin_o(sin_o), .cos_o(cos_o)
  );

  // Counts clean edges since reset so three-deep history checks are valid
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R1: reset clears both outputs on the next edge
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (sin_o == '0) && (cos_o == '0));

  // R7: raw path delivers the words sampled three edges earlier
  a_r7_raw_pass: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) && !$past(raw_sel_n_i, 3) |->
      (sin_o == OUT_W'($past(phase_sum_i, 3))) && (cos_o == OUT_W'($past(acc_lo_i, 3))));

  // R5: half-turn table mode yields a non-negative sine
  a_r5_half_nonneg: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) && $past(raw_sel_n_i, 3) && $past(half_turn_i, 3) |->
      !sin_o[OUT_W-1]);
endmodule

// File: tb/sim_quad_sincos_lut.sv
`timescale 1ns/1ps
module sim_quad_sincos_lut;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] phase = '0, acc = '0;
  logic        byp_n = 1'b1, half = 1'b0;
  logic [15:0] cos_w, sin_w;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  quad_sincos_lut u0 (
    .clk(clk), .rst(rst), .phase_sum_i(phase), .acc_lo_i(acc),
    .raw_sel_n_i(byp_n), .half_turn_i(half), .cos_o(cos_w), .sin_o(sin_w)
  );

  function automatic int qtab(int j);
    return $rtoi(32767.0 * $sin(1.5707963267948966 * (real'(j) + 0.5) / 256.0) + 0.5);
  endfunction

  function automatic logic [15:0] tab_val(logic [9:0] a);
    logic [7:0] i;
    int m;
    i = a[8] ? ~a[7:0] : a[7:0];
    m = qtab(int'(i));
    return a[9] ? 16'(-m) : 16'(m);
  endfunction

  function automatic logic [31:0] expect_pair(logic [15:0] ph, logic [15:0] ac,
                                              logic bn, logic hf);
    logic [9:0] a;
    if (!bn) return {ac, ph};
    a = ph[15:6];
    if (hf) a[9] = 1'b0;
    return {tab_val(a + 10'd256), tab_val(a)};
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic run_one(string req, logic [15:0] ph, logic [15:0] ac, logic bn, logic hf);
    logic [31:0] e;
    phase = ph; acc = ac; byp_n = bn; half = hf;
    e = expect_pair(ph, ac, bn, hf);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({req, " sin"}, sin_w, e[15:0]);
    check({req, " cos"}, cos_w, e[31:16]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset sin", sin_w, 16'h0);
    check("R1 reset cos", cos_w, 16'h0);
    rst = 1'b0;
    run_one("R3", 16'h2000, 16'h0, 1'b1, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset sin", sin_w, 16'h0);
    check("R1 mid-run reset cos", cos_w, 16'h0);
    rst = 1'b0;
  endtask

  task automatic t_quadrants();
    logic [9:0] idx [9] = '{10'd0, 10'd255, 10'd256, 10'd511, 10'd512,
                            10'd767, 10'd768, 10'd1023, 10'd300};
    foreach (idx[k]) run_one("R3/R4 quadrant", {idx[k], 6'b0}, 16'h0, 1'b1, 1'b0);
    run_one("R3 first entry sin", 16'h0000, 16'h0, 1'b1, 1'b0);
    check("R3 T[0] value", sin_w, 16'(qtab(0)));
    check("R4 cos near full scale", cos_w, 16'(qtab(255)));
  endtask

  task automatic t_low_bits();
    run_one("R8 low bits", 16'h5A3F, 16'hFFFF, 1'b1, 1'b0);
    check("R8 matches clean phase sin", sin_w, expect_pair(16'h5A00, 0, 1'b1, 1'b0) >> 0 & 32'hFFFF);
  endtask

  task automatic t_half_turn();
    logic [31:0] base;
    base = expect_pair(16'h1040, 16'h0, 1'b1, 1'b0);
    run_one("R5 half-turn", 16'h9040, 16'h0, 1'b1, 1'b1);
    check("R5 aliases to lower half sin", sin_w, base[15:0]);
    check("R5 aliases to lower half cos", cos_w, base[31:16]);
    run_one("R5 half-turn top", 16'hFFC0, 16'h0, 1'b1, 1'b1);
    check("R5 sine non-negative", {15'h0, sin_w[15]}, 16'h0);
  endtask

  task automatic t_raw();
    run_one("R7 raw", 16'hA5A5, 16'h5A5A, 1'b0, 1'b0);
    run_one("R7 raw with half-turn", 16'hF00F, 16'h8001, 1'b0, 1'b1);
  endtask

  task automatic t_stream();
    logic [31:0] exp_q [24];
    for (int n = 0; n < 24; n++) begin
      @(negedge clk);
      if (n >= 3) begin
        check("R2/R6 stream sin", sin_w, exp_q[n-3][15:0]);
        check("R2/R6 stream cos", cos_w, exp_q[n-3][31:16]);
      end
      if (n < 21) begin
        phase = 16'(n * 16'h0B47 + 16'h0133);
        acc   = 16'(n * 16'h1111);
        byp_n = (n % 3) != 1;
        half  = (n % 2) == 0;
        exp_q[n] = expect_pair(phase, acc, byp_n, half);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_quadrants();
    t_low_bits();
    t_half_turn();
    t_raw();
    t_stream();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule